// File: doc/BRIEF.md
# Segment Descriptor Table Lookup Unit

This unit turns a 16-bit segment selector into the 8-byte segment descriptor it names. Selector bit 2 picks either the global table (base and limit supplied as inputs) or the local table (base and limit held inside the unit). The unit clears the selector's three low bits to get a byte offset, tests that offset against the chosen table's limit, and fetches the descriptor as two 32-bit words over a simple memory read port with a ready handshake. It then splits the two words into base, expanded limit, type, privilege level and present bit.

A second command loads the local table register. A selector whose bits 15:2 are all zero clears the local table. Any other selector is looked up in the tables, and its descriptor must be a local-table descriptor that is present. When all checks pass, the local base, expanded limit and selector are replaced. A failed check raises a general-protection or not-present fault, with the selector as the error value, and leaves the local registers as they were.

Each command ends with a one-cycle acknowledge. Any fault is reported in the same cycle.

Top module: `dtl_lookup_unit`

## Requirements
- R1: After a synchronous active-high reset, every output is zero, including the local table base, limit and selector.
- R2: The table byte offset is the selector with bits 2:0 forced to zero. The descriptor is read as two words: first at table base plus offset, then at that address plus 4. While mem_ready is low, mem_req stays high and mem_addr does not change.
- R3: When selector bit 2 is 1, the local table base and limit are used. When it is 0, gtab_base and gtab_limit are used.
- R4: If the offset is greater than or equal to the selected limit, the command faults with vector 13 and error code equal to the selector, and no memory read is issued. This applies to both command types.
- R5: dsc_base is first-word bits 31:16 in bits 15:0, second-word bits 7:0 in bits 23:16, and second-word bits 31:24 in bits 31:24.
- R6: The raw 20-bit limit is first-word bits 15:0 with second-word bits 19:16 on top. When second-word bit 23 (granularity) is set, dsc_limit is raw limit shifted left by 12 with 0xFFF in the low bits. Otherwise dsc_limit is the raw limit.
- R7: dsc_type is second-word bits 12:8, dsc_dpl is bits 14:13, and dsc_present is bit 15. These outputs are zero when no descriptor was fetched.
- R8: A load-local command (cmd_op = 1) whose selector has bits 15:2 all zero clears the local base, limit and selector to zero. It raises no fault and reads no memory.
- R9: For a non-null load-local command, the checks run in this order: a lookup failure gives vector 13, then a type other than 2 gives vector 13, then a clear present bit gives vector 11. The error code is always the selector, and a fault leaves the local registers unchanged.
- R10: A load-local command that passes every check sets the local base and limit to the fetched descriptor's base and expanded limit, and sets the local selector to the command's selector. These registers change only in the acknowledge cycle.
- R11: cmd_ack is high for exactly one cycle per accepted command, and flt_valid is high only in that cycle. A cmd_valid raised while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_op | input | 1 | 0 = descriptor lookup, 1 = load local table |
| cmd_sel | input | 16 | Segment selector |
| cmd_ack | output | 1 | One-cycle completion pulse |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 32 | Global table limit in bytes |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ready | input | 1 | Read data valid; completes the read |
| mem_rdata | input | 32 | Read data word |
| dsc_base | output | 32 | Descriptor base |
| dsc_limit | output | 32 | Descriptor limit after granularity expansion |
| dsc_type | output | 5 | Descriptor type field |
| dsc_dpl | output | 2 | Descriptor privilege level |
| dsc_present | output | 1 | Descriptor present bit |
| flt_valid | output | 1 | Fault flag, high together with cmd_ack |
| flt_vector | output | 8 | Fault vector (13 general protection, 11 not present) |
| flt_code | output | 16 | Fault error value (the selector) |
| ltab_base | output | 32 | Local table base |
| ltab_limit | output | 32 | Local table limit |
| ltab_sel | output | 16 | Local table selector |

## Verification
The assertions assume the memory side keeps its ready signal meaningful only while a read is requested. They also assume reset is asserted from the first clock, because the register-change property compares against the previous cycle. The bench memory model raises ready only while a read is requested, after a chosen number of wait cycles, and reset is held high from time zero. New commands are issued only after the previous acknowledge, except for one deliberate request injected while a fetch is in progress, which the unit must ignore.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ_LO,
      ST_READ_HI,
      ST_CHECK,
      ST_DONE
   } dtl_state_e;

   localparam logic [7:0] VEC_GENPROT  = 8'd13;
   localparam logic [7:0] VEC_NOTPRES  = 8'd11;
   localparam logic [4:0] KIND_LOCALTAB = 5'd2;

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] limit;
      logic [4:0]  kind;
      logic [1:0]  dpl;
      logic        present;
   } dtl_desc_t;
endpackage

// File: rtl/dtl_table_sel.sv
module dtl_table_sel #(
   parameter int SEL_W  = 16,
   parameter int ADDR_W = 32
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] gbase,
   input  logic [ADDR_W-1:0] glimit,
   input  logic [ADDR_W-1:0] lbase,
   input  logic [ADDR_W-1:0] llimit,
   output logic [ADDR_W-1:0] addr,
   output logic              out_of_range
);
   localparam int PAD_W = ADDR_W - SEL_W;

   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] tbase;
   logic [ADDR_W-1:0] tlimit;
   logic [1:0]        unused_rpl;

   assign unused_rpl = sel[1:0];
   assign offset = {{PAD_W{1'b0}}, sel[SEL_W-1:3], 3'b000};
   assign tbase  = sel[2] ? lbase  : gbase;
   assign tlimit = sel[2] ? llimit : glimit;
   assign out_of_range = (offset >= tlimit);
   assign addr = tbase + offset;
endmodule

// File: rtl/dtl_desc_decode.sv
module dtl_desc_decode
   import dtl_pkg::*;
#(
   parameter bit GRAN_EN = 1'b1
) (
   input  logic [31:0] word_lo,
   input  logic [31:0] word_hi,
   output dtl_desc_t   desc
);
   logic [19:0] raw_limit;
   logic [2:0]  unused_flags;

   assign unused_flags = word_hi[22:20];
   assign raw_limit = {word_hi[19:16], word_lo[15:0]};

   always_comb begin
      desc.base    = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
      desc.kind    = word_hi[12:8];
      desc.dpl     = word_hi[14:13];
      desc.present = word_hi[15];
   end

   generate
      if (GRAN_EN) begin : g_gran
         assign desc.limit = word_hi[23] ? {raw_limit, 12'hFFF} : {12'h000, raw_limit};
      end else begin : g_bytes
         logic unused_gran;
         assign unused_gran = word_hi[23];
         assign desc.limit = {12'h000, raw_limit};
      end
   endgenerate
endmodule

// File: rtl/dtl_local_regs.sv
module dtl_local_regs #(
   parameter int SEL_W  = 16,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              ld,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [ADDR_W-1:0] limit_in,
   input  logic [SEL_W-1:0]  sel_in,
   output logic [ADDR_W-1:0] base_q,
   output logic [ADDR_W-1:0] limit_q,
   output logic [SEL_W-1:0]  sel_q
);
   always_ff @(posedge clk) begin
      if (rst || clr) begin
         base_q  <= '0;
         limit_q <= '0;
         sel_q   <= '0;
      end else if (ld) begin
         base_q  <= base_in;
         limit_q <= limit_in;
         sel_q   <= sel_in;
      end
   end
endmodule

// File: rtl/dtl_lookup_unit.sv
module dtl_lookup_unit
   import dtl_pkg::*;
#(
   parameter int SEL_W   = 16,
   parameter int ADDR_W  = 32,
   parameter bit GRAN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic [SEL_W-1:0]  cmd_sel,
   output logic              cmd_ack,
   input  logic [ADDR_W-1:0] gtab_base,
   input  logic [ADDR_W-1:0] gtab_limit,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic [31:0]       dsc_base,
   output logic [31:0]       dsc_limit,
   output logic [4:0]        dsc_type,
   output logic [1:0]        dsc_dpl,
   output logic              dsc_present,
   output logic              flt_valid,
   output logic [7:0]        flt_vector,
   output logic [SEL_W-1:0]  flt_code,
   output logic [ADDR_W-1:0] ltab_base,
   output logic [ADDR_W-1:0] ltab_limit,
   output logic [SEL_W-1:0]  ltab_sel
);
   localparam int WORD_BYTES = 4;
   localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(WORD_BYTES);

   generate
      if (SEL_W != 16) begin : g_bad_sel
         $error("dtl_lookup_unit: SEL_W must be 16");
      end
      if (ADDR_W != 32) begin : g_bad_addr
         $error("dtl_lookup_unit: ADDR_W must be 32");
      end
   endgenerate

   dtl_state_e        st;
   logic              op_q;
   logic [SEL_W-1:0]  sel_q;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       wlo_q;
   logic [31:0]       whi_q;
   logic              fpend_q;

   logic [ADDR_W-1:0] tbl_addr;
   logic              tbl_oob;
   dtl_desc_t         dec;
   logic              accept;
   logic              null_load;
   logic              lt_clr;
   logic              lt_ld;

   dtl_table_sel #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_tsel (
      .sel          (cmd_sel),
      .gbase        (gtab_base),
      .glimit       (gtab_limit),
      .lbase        (ltab_base),
      .llimit       (ltab_limit),
      .addr         (tbl_addr),
      .out_of_range (tbl_oob)
   );

   dtl_desc_decode #(.GRAN_EN(GRAN_EN)) u_dec (
      .word_lo (wlo_q),
      .word_hi (whi_q),
      .desc    (dec)
   );

   assign accept    = (st == ST_IDLE) && cmd_valid;
   assign null_load = cmd_op && (cmd_sel[SEL_W-1:2] == '0);
   assign lt_clr    = accept && null_load;
   assign lt_ld     = (st == ST_CHECK) && op_q && (dec.kind == KIND_LOCALTAB) && dec.present;

   dtl_local_regs #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_lregs (
      .clk      (clk),
      .rst      (rst),
      .clr      (lt_clr),
      .ld       (lt_ld),
      .base_in  (dec.base),
      .limit_in (dec.limit),
      .sel_in   (sel_q),
      .base_q   (ltab_base),
      .limit_q  (ltab_limit),
      .sel_q    (ltab_sel)
   );

   assign mem_req   = (st == ST_READ_LO) || (st == ST_READ_HI);
   assign mem_addr  = (st == ST_READ_HI) ? addr_q + HI_STEP : addr_q;
   assign cmd_ack   = (st == ST_DONE);
   assign flt_valid = (st == ST_DONE) && fpend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st          <= ST_IDLE;
         op_q        <= 1'b0;
         sel_q       <= '0;
         addr_q      <= '0;
         wlo_q       <= '0;
         whi_q       <= '0;
         fpend_q     <= 1'b0;
         flt_vector  <= '0;
         flt_code    <= '0;
         dsc_base    <= '0;
         dsc_limit   <= '0;
         dsc_type    <= '0;
         dsc_dpl     <= '0;
         dsc_present <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_q        <= cmd_op;
                  sel_q       <= cmd_sel;
                  fpend_q     <= 1'b0;
                  flt_vector  <= '0;
                  flt_code    <= '0;
                  dsc_base    <= '0;
                  dsc_limit   <= '0;
                  dsc_type    <= '0;
                  dsc_dpl     <= '0;
                  dsc_present <= 1'b0;
                  if (null_load) begin
                     st <= ST_DONE;
                  end else if (tbl_oob) begin
                     fpend_q    <= 1'b1;
                     flt_vector <= VEC_GENPROT;
                     flt_code   <= cmd_sel;
                     st         <= ST_DONE;
                  end else begin
                     addr_q <= tbl_addr;
                     st     <= ST_READ_LO;
                  end
               end
            end
            ST_READ_LO: begin
               if (mem_ready) begin
                  wlo_q <= mem_rdata;
                  st    <= ST_READ_HI;
               end
            end
            ST_READ_HI: begin
               if (mem_ready) begin
                  whi_q <= mem_rdata;
                  st    <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               dsc_base    <= dec.base;
               dsc_limit   <= dec.limit;
               dsc_type    <= dec.kind;
               dsc_dpl     <= dec.dpl;
               dsc_present <= dec.present;
               if (op_q) begin
                  if (dec.kind != KIND_LOCALTAB) begin
                     fpend_q    <= 1'b1;
                     flt_vector <= VEC_GENPROT;
                     flt_code   <= sel_q;
                  end else if (!dec.present) begin
                     fpend_q    <= 1'b1;
                     flt_vector <= VEC_NOTPRES;
                     flt_code   <= sel_q;
                  end
               end
               st <= ST_DONE;
            end
            default: begin
               fpend_q <= 1'b0;
               st      <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/dtl_lookup_unit_chk.sv
module dtl_lookup_unit_chk #(
   parameter int SEL_W  = 16,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_ack,
   input logic              flt_valid,
   input logic [7:0]        flt_vector,
   input logic              mem_req,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] ltab_base,
   input logic [ADDR_W-1:0] ltab_limit,
   input logic [SEL_W-1:0]  ltab_sel
);
   a_r11_ack_pulse: assert property (@(posedge clk) disable iff (rst)
      cmd_ack |=> !cmd_ack);

   a_r11_fault_with_ack: assert property (@(posedge clk) disable iff (rst)
      flt_valid |-> cmd_ack);

   a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   a_r2_no_ack_in_read: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !cmd_ack);

   a_r9_vector_legal: assert property (@(posedge clk) disable iff (rst)
      flt_valid |-> (flt_vector == 8'd13 || flt_vector == 8'd11));

   a_r9_fault_keeps_regs: assert property (@(posedge clk) disable iff (rst)
      (cmd_ack && flt_valid) |-> ($stable(ltab_base) && $stable(ltab_limit) && $stable(ltab_sel)));

   a_r10_regs_move_on_ack: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !($stable(ltab_base) && $stable(ltab_limit) && $stable(ltab_sel))) |-> cmd_ack);
endmodule

bind dtl_lookup_unit dtl_lookup_unit_chk #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cmd_ack    (cmd_ack),
   .flt_valid  (flt_valid),
   .flt_vector (flt_vector),
   .mem_req    (mem_req),
   .mem_ready  (mem_ready),
   .mem_addr   (mem_addr),
   .ltab_base  (ltab_base),
   .ltab_limit (ltab_limit),
   .ltab_sel   (ltab_sel)
);

// File: tb/dtl_lookup_unit_test.sv
module dtl_lookup_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic        cmd_op = 1'b0;
   logic [15:0] cmd_sel = '0;
   logic        cmd_ack;
   logic [31:0] gtab_base = 32'h100;
   logic [31:0] gtab_limit = 32'h40;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] dsc_base, dsc_limit;
   logic [4:0]  dsc_type;
   logic [1:0]  dsc_dpl;
   logic        dsc_present;
   logic        flt_valid;
   logic [7:0]  flt_vector;
   logic [15:0] flt_code;
   logic [31:0] ltab_base, ltab_limit;
   logic [15:0] ltab_sel;

   always #2 clk = ~clk;

   dtl_lookup_unit uut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
      .cmd_ack(cmd_ack), .gtab_base(gtab_base), .gtab_limit(gtab_limit),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .dsc_base(dsc_base), .dsc_limit(dsc_limit), .dsc_type(dsc_type), .dsc_dpl(dsc_dpl),
      .dsc_present(dsc_present), .flt_valid(flt_valid), .flt_vector(flt_vector),
      .flt_code(flt_code), .ltab_base(ltab_base), .ltab_limit(ltab_limit), .ltab_sel(ltab_sel)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int resp_lat = 0;
   int wait_cnt = 0;
   logic [31:0] mem [0:255];

   bit [31:0] m_lbase = 0;
   bit [31:0] m_llimit = 0;
   bit [15:0] m_lsel = 0;

   task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 60000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (mem_req) begin
         if (wait_cnt >= resp_lat) begin
            mem_ready <= 1'b1;
            mem_rdata <= mem[(mem_addr >> 2) & 32'hFF];
            wait_cnt  <= 0;
         end else begin
            mem_ready <= 1'b0;
            wait_cnt  <= wait_cnt + 1;
         end
      end else begin
         mem_ready <= 1'b0;
         wait_cnt  <= 0;
      end
   end

   task automatic put_desc(input int addr, input bit [31:0] base, input bit [19:0] lim,
                           input bit [4:0] kind, input bit [1:0] dpl, input bit p, input bit g);
      bit [31:0] lo, hi;
      lo = {base[15:0], lim[15:0]};
      hi = 0;
      hi = hi | (base & 32'hFF000000);
      hi = hi | (32'(g) << 23);
      hi = hi | (32'(lim >> 16) << 16);
      hi = hi | (32'(p) << 15);
      hi = hi | (32'(dpl) << 13);
      hi = hi | (32'(kind) << 8);
      hi = hi | ((base >> 16) & 32'hFF);
      mem[(addr >> 2) & 255] = lo;
      mem[((addr + 4) >> 2) & 255] = hi;
   endtask

   task automatic run_cmd(input bit op, input bit [15:0] sel, input int lat, input bit inject);
      bit [31:0] tb, tl, off, w0, w1, eb, el, ra;
      bit [4:0]  et;
      bit [1:0]  ed;
      bit        ep, efl, fetch;
      bit [7:0]  ev;
      bit [31:0] nb, nl;
      bit [15:0] ns;
      bit [31:0] addrs[$];
      int n;
      tb = sel[2] ? m_lbase : gtab_base;
      tl = sel[2] ? m_llimit : gtab_limit;
      off = 32'(sel) & 32'hFFF8;
      eb = 0; el = 0; et = 0; ed = 0; ep = 0; efl = 0; ev = 0; fetch = 0;
      nb = m_lbase; nl = m_llimit; ns = m_lsel;
      ra = tb + off;
      if (op && (sel >> 2) == 0) begin
         nb = 0; nl = 0; ns = 0;
      end else if (off >= tl) begin
         efl = 1; ev = 13;
      end else begin
         fetch = 1;
         w0 = mem[(ra >> 2) & 255];
         w1 = mem[((ra + 4) >> 2) & 255];
         eb = (w1 & 32'hFF000000) | ((w1 & 32'hFF) << 16) | (w0 >> 16);
         el = (((w1 >> 16) & 32'hF) << 16) | (w0 & 32'hFFFF);
         if (((w1 >> 23) & 1) == 1) el = el * 4096 + 4095;
         et = 5'((w1 >> 8) & 32'h1F);
         ed = 2'((w1 >> 13) & 3);
         ep = w1[15];
         if (op) begin
            if (et != 2) begin efl = 1; ev = 13; end
            else if (!ep) begin efl = 1; ev = 11; end
            else begin nb = eb; nl = el; ns = sel; end
         end
      end
      resp_lat = lat;
      @(negedge clk); #1;
      cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel;
      @(negedge clk); #1;
      cmd_valid = 1'b0;
      n = 0;
      while (!cmd_ack && n < 300) begin
         if (mem_req && mem_ready) addrs.push_back(mem_addr);
         chk("R10 local base held while busy", ltab_base, m_lbase);
         chk("R10 local selector held while busy", 32'(ltab_sel), 32'(m_lsel));
         if (inject && n == 0) begin
            cmd_valid = 1'b1; cmd_op = 1'b1; cmd_sel = 16'h0003;
         end
         if (n == 1) cmd_valid = 1'b0;
         @(negedge clk); #1;
         n++;
      end
      cmd_valid = 1'b0;
      chk("R11 ack seen", 32'(cmd_ack), 1);
      chk("R4 R9 fault flag", 32'(flt_valid), 32'(efl));
      chk("R4 R9 fault vector", 32'(flt_vector), 32'(ev));
      chk("R4 R9 fault code", 32'(flt_code), efl ? 32'(sel) : 0);
      chk("R5 descriptor base", dsc_base, eb);
      chk("R6 descriptor limit", dsc_limit, el);
      chk("R7 descriptor type", 32'(dsc_type), 32'(et));
      chk("R7 descriptor dpl", 32'(dsc_dpl), 32'(ed));
      chk("R7 descriptor present", 32'(dsc_present), 32'(ep));
      chk("R4 R8 read count", addrs.size(), fetch ? 2 : 0);
      if (fetch && addrs.size() == 2) begin
         chk("R2 R3 first read address", addrs[0], ra);
         chk("R2 second read address", addrs[1], ra + 4);
      end
      m_lbase = nb; m_llimit = nl; m_lsel = ns;
      chk("R8 R9 R10 local base", ltab_base, m_lbase);
      chk("R8 R9 R10 local limit", ltab_limit, m_llimit);
      chk("R8 R9 R10 local selector", 32'(ltab_sel), 32'(m_lsel));
      @(negedge clk); #1;
      chk("R11 ack one cycle", 32'(cmd_ack), 0);
      chk("R11 fault one cycle", 32'(flt_valid), 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      put_desc(32'h108, 32'h12345678, 20'h0ABCD, 5'h1A, 2'd3, 1'b1, 1'b0);
      put_desc(32'h110, 32'h00000200, 20'h0001F, 5'h02, 2'd0, 1'b1, 1'b0);
      put_desc(32'h118, 32'h00000280, 20'h0001F, 5'h02, 2'd0, 1'b0, 1'b0);
      put_desc(32'h120, 32'h00000280, 20'h0001F, 5'h12, 2'd0, 1'b1, 1'b0);
      put_desc(32'h128, 32'h00000300, 20'h00000, 5'h02, 2'd1, 1'b1, 1'b1);
      put_desc(32'h138, 32'hCAFE0011, 20'h00007, 5'h10, 2'd1, 1'b1, 1'b0);
      put_desc(32'h208, 32'hDE00BEEF, 20'h00012, 5'h13, 2'd2, 1'b1, 1'b1);
      put_desc(32'h218, 32'h0F0F0F0F, 20'hF1234, 5'h1E, 2'd1, 1'b0, 1'b0);
      put_desc(32'h300, 32'hA5A55A5A, 20'h0FFFF, 5'h1E, 2'd1, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      #1;
      chk("R1 ack after reset", 32'(cmd_ack), 0);
      chk("R1 mem_req after reset", 32'(mem_req), 0);
      chk("R1 mem_addr after reset", mem_addr, 0);
      chk("R1 fault after reset", 32'(flt_valid), 0);
      chk("R1 descriptor base after reset", dsc_base, 0);
      chk("R1 local base after reset", ltab_base, 0);
      chk("R1 local limit after reset", ltab_limit, 0);
      chk("R1 local selector after reset", 32'(ltab_sel), 0);
      rst = 1'b0;
      run_cmd(1'b0, 16'h000B, 0, 1'b0);   // R2 R5 R6 R7 global lookup
      run_cmd(1'b0, 16'h003F, 1, 1'b0);   // R4 last valid slot
      run_cmd(1'b0, 16'h0040, 0, 1'b0);   // R4 offset equals limit
      run_cmd(1'b0, 16'h000C, 0, 1'b0);   // R3 empty local table
      run_cmd(1'b1, 16'h0018, 0, 1'b0);   // R9 not present
      run_cmd(1'b1, 16'h0020, 0, 1'b0);   // R9 wrong type
      run_cmd(1'b1, 16'h0050, 0, 1'b0);   // R9 lookup fault
      run_cmd(1'b1, 16'h0010, 2, 1'b1);   // R10 R11 load with injected request
      run_cmd(1'b0, 16'h000C, 3, 1'b0);   // R3 R6 local lookup, granular
      run_cmd(1'b0, 16'h001E, 0, 1'b0);   // R3 R7 local slot 3, not present
      run_cmd(1'b0, 16'h0024, 0, 1'b0);   // R3 R4 past local limit
      run_cmd(1'b1, 16'h001C, 0, 1'b0);   // R9 local descriptor of wrong type
      run_cmd(1'b1, 16'h002B, 1, 1'b0);   // R6 R10 granular local table
      run_cmd(1'b0, 16'h0007, 0, 1'b0);   // R3 lookup in new local table
      run_cmd(1'b1, 16'h0003, 0, 1'b0);   // R8 null load
      run_cmd(1'b0, 16'h0004, 0, 1'b0);   // R3 R8 local table now empty
      run_cmd(1'b1, 16'h0000, 0, 1'b0);   // R8 null load again
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule